// File: doc/BRIEF.md
# Round-Trip Delay Measurement Unit

This block sits in the line-termination side of a two-wire digital subscriber line transceiver. It estimates how long a frame takes to go out and come back. The estimate is kept as three separate results, and software adds them together later:

- **Coarse term.** This is the number of transmit baud periods counted from the local transmit frame-sync strobe to the recovered receive frame-sync strobe. At 80 kbaud one baud period is 12.5 µs.
- **Elastic correction.** This is the fill level of the receive elastic buffer, captured when the receive strobe ends the count.
- **Fine term.** This is the phase between the transmit and receive baud clocks. It is counted in cycles of the fast reference clock. At 15.36 MHz one cycle is about 65.1 ns, which gives an overall resolution of roughly ±33 ns.

The one-way link delay is half the round-trip value plus a fixed offset.

All logic runs on the fast reference clock. The frame strobes and the two baud edges arrive as one-cycle pulses in that clock domain. A measurement starts on every transmit frame strobe.

Software uses a small read port:

- Reading the status word returns the status bits and clears the valid flag.
- The same read copies all three results into shadow registers.
- Later reads of the three result words return the shadow copies. The values read therefore belong together, even while a new measurement is running.

Top module: `rtd_measure_unit`

## Requirements
- R1: After reset, the status word reads 0, and the coarse, elastic and fine result words all read 0.
- R2: The coarse result equals the number of `baud_tick` pulses that arrive after the `tx_fsync` cycle and before the `rx_fsync` cycle. The coarse result is latched on the `rx_fsync` cycle, and that ends the measurement.
- R3: Timeout. If `FRAME_BAUDS` ticks arrive without an `rx_fsync`:
  - the coarse result saturates at `FRAME_BAUDS`;
  - the timeout flag is set;
  - counting stops;
  - a later `rx_fsync` has no effect on any result.
- R4: `eb_fill` is captured into the elastic result only on an `rx_fsync` that ends a running measurement. At any other time it is ignored.
- R5: The fine result is the number of clock cycles from the first `baud_tick` after `tx_fsync` to the next `rx_baud_tick`.
  - Any `rx_baud_tick` that arrives before that start edge is ignored.
  - The count saturates at 2^`FINE_W`−1.
- R6: The valid flag is set once both the coarse result and the fine result have been completed by `rx_fsync` and `rx_baud_tick` since the last `tx_fsync`. A `tx_fsync` clears both valid and timeout.
- R7: Reading the status word returns valid in bit 0, timeout in bit 1 and busy in bit 2.
  - The read returns the flags as they were before the read.
  - The read clears valid, unless valid is being set in that same cycle.
  - The read copies the three results into shadow registers.
- R8: All reads put their data on `rd_data` in the cycle after `rd_en`. The word is selected by `rd_sel` (0 = status, 1 = coarse, 2 = elastic, 3 = fine), and results are read from the shadow registers. `rd_data` holds its value while no read is made.
- R9: A `tx_fsync` that arrives during a running measurement restarts the coarse count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock (15.36 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_fsync | input | 1 | Transmit frame-sync strobe; starts a measurement |
| rx_fsync | input | 1 | Recovered receive frame-sync strobe; stops the coarse count |
| baud_tick | input | 1 | Transmit baud clock edge pulse |
| rx_baud_tick | input | 1 | Receive baud clock edge pulse |
| eb_fill | input | FILL_W | Current receive elastic buffer fill level |
| rd_en | input | 1 | Read request |
| rd_sel | input | 2 | Word select: 0 status, 1 coarse, 2 elastic, 3 fine |
| rd_data | output | DATA_W | Read data, valid the cycle after `rd_en` |

## Verification
The hardest condition to reach from the ports is a shadow snapshot that stays unchanged while a second measurement completes underneath it. The stimulus finishes one measurement, reads the status word, then runs a second complete measurement with different counts. Only after that does it read the coarse word, expecting the first value, and then it reads status again to fetch the second value. The timeout path is reached by supplying a full frame of transmit baud ticks with no receive strobe. A late receive strobe is then applied, with a changed fill level, so that any stray capture would be visible.

// File: rtl/rtd_pkg.sv
// Package: shared read-select codes and status bit positions for the
// round-trip delay measurement unit.
package rtd_pkg;

    typedef enum logic [1:0] {
        SEL_STATUS  = 2'd0,
        SEL_COARSE  = 2'd1,
        SEL_ELASTIC = 2'd2,
        SEL_PHASE   = 2'd3
    } rd_sel_e;

    localparam int ST_VALID   = 0;
    localparam int ST_TIMEOUT = 1;
    localparam int ST_BUSY    = 2;

endpackage

// File: rtl/rtd_coarse_timer.sv
// Coarse timer: counts transmit baud ticks from the transmit frame strobe
// to the receive frame strobe.
// It saturates at FRAME_BAUDS and raises a timeout if no receive strobe
// arrives in time.
// Assumes all strobes are single-cycle pulses in the clk domain.
module rtd_coarse_timer #(
    parameter int FRAME_BAUDS = 120,
    parameter int COARSE_W    = $clog2(FRAME_BAUDS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_fsync,
    input  logic                rx_fsync,
    input  logic                baud_tick,
    output logic                running,
    output logic [COARSE_W-1:0] cnt,
    output logic [COARSE_W-1:0] result,
    output logic                timeout,
    output logic                done
);

    localparam logic [COARSE_W-1:0] LAST = COARSE_W'(FRAME_BAUDS - 1);
    localparam logic [COARSE_W-1:0] SAT  = COARSE_W'(FRAME_BAUDS);

    // Stop pulse: the receive strobe closes a running measurement.
    assign done = running && rx_fsync && !tx_fsync;

    // Counter, run state, latched result and timeout flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
            result  <= '0;
            timeout <= 1'b0;
        end else if (tx_fsync) begin
            running <= 1'b1;
            cnt     <= '0;
            timeout <= 1'b0;
        end else if (running) begin
            if (rx_fsync) begin
                result  <= cnt;
                running <= 1'b0;
            end else if (baud_tick) begin
                if (cnt == LAST) begin
                    cnt     <= SAT;
                    result  <= SAT;
                    timeout <= 1'b1;
                    running <= 1'b0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rtd_phase_counter.sv
// Phase counter: counts fast-clock cycles from the first transmit baud
// edge after a frame strobe to the next receive baud edge. The count
// saturates at all-ones.
// Assumes the baud edges are single-cycle pulses in the clk domain.
module rtd_phase_counter #(
    parameter int FINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_fsync,
    input  logic              baud_tick,
    input  logic              rx_baud_tick,
    output logic [FINE_W-1:0] result,
    output logic              done
);

    localparam logic [FINE_W-1:0] MAXV = '1;

    logic              armed;
    logic              run;
    logic [FINE_W-1:0] cnt;

    // Stop pulse: a receive baud edge closes a running phase count.
    assign done = run && rx_baud_tick && !tx_fsync;

    // Arm on the frame strobe, start on a transmit edge, stop on a receive edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed  <= 1'b0;
            run    <= 1'b0;
            cnt    <= '0;
            result <= '0;
        end else if (tx_fsync) begin
            armed <= 1'b1;
            run   <= 1'b0;
        end else if (run) begin
            if (rx_baud_tick) begin
                result <= cnt;
                run    <= 1'b0;
            end else if (cnt != MAXV) begin
                cnt <= cnt + 1'b1;
            end
        end else if (armed && baud_tick) begin
            armed <= 1'b0;
            run   <= 1'b1;
            cnt   <= FINE_W'(1);
        end
    end

endmodule

// File: rtl/rtd_regfile.sv
// Register file: captures the elastic fill and tracks the completion of
// one measurement. It also serves the read port from shadow copies that
// are taken on every status read.
// Assumes rd_en is a single-cycle request.
module rtd_regfile
    import rtd_pkg::*;
#(
    parameter int COARSE_W = 7,
    parameter int FILL_W   = 4,
    parameter int FINE_W   = 8,
    parameter int DATA_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_fsync,
    input  logic                coarse_done,
    input  logic                fine_done,
    input  logic                busy,
    input  logic                timeout,
    input  logic [COARSE_W-1:0] coarse_res,
    input  logic [FINE_W-1:0]   fine_res,
    input  logic [FILL_W-1:0]   eb_fill,
    input  logic                rd_en,
    input  logic [1:0]          rd_sel,
    output logic                valid,
    output logic [DATA_W-1:0]   rd_data
);

    logic                coarse_ok;
    logic                fine_ok;
    logic                valid_set;
    logic                rd_status;
    logic [FILL_W-1:0]   fill_live;
    logic [COARSE_W-1:0] coarse_sh;
    logic [FILL_W-1:0]   fill_sh;
    logic [FINE_W-1:0]   fine_sh;
    rd_sel_e             sel;

    assign sel       = rd_sel_e'(rd_sel);
    assign rd_status = rd_en && (sel == SEL_STATUS);
    // Both halves of the same measurement are complete for the first time.
    assign valid_set = (coarse_ok || coarse_done) && (fine_ok || fine_done)
                       && !(coarse_ok && fine_ok);

    // Completion tracking, elastic capture and the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coarse_ok <= 1'b0;
            fine_ok   <= 1'b0;
            valid     <= 1'b0;
            fill_live <= '0;
        end else if (tx_fsync) begin
            coarse_ok <= 1'b0;
            fine_ok   <= 1'b0;
            valid     <= 1'b0;
        end else begin
            if (coarse_done) begin
                coarse_ok <= 1'b1;
                fill_live <= eb_fill;
            end
            if (fine_done) fine_ok <= 1'b1;
            if (valid_set)      valid <= 1'b1;
            else if (rd_status) valid <= 1'b0;
        end
    end

    // Shadow snapshot on status read, and the registered read mux.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coarse_sh <= '0;
            fill_sh   <= '0;
            fine_sh   <= '0;
            rd_data   <= '0;
        end else if (rd_en) begin
            unique case (sel)
                SEL_STATUS: begin
                    coarse_sh        <= coarse_res;
                    fill_sh          <= fill_live;
                    fine_sh          <= fine_res;
                    rd_data          <= '0;
                    rd_data[ST_VALID]   <= valid;
                    rd_data[ST_TIMEOUT] <= timeout;
                    rd_data[ST_BUSY]    <= busy;
                end
                SEL_COARSE:  rd_data <= DATA_W'(coarse_sh);
                SEL_ELASTIC: rd_data <= DATA_W'(fill_sh);
                SEL_PHASE:   rd_data <= DATA_W'(fine_sh);
            endcase
        end
    end

endmodule

// File: rtl/rtd_measure_unit.sv
// Top level: round-trip delay measurement. It joins the coarse baud timer,
// the fine phase counter and the register file with its shadow read port.
// Assumes every input is synchronous to clk.
module rtd_measure_unit #(
    parameter int FRAME_BAUDS = 120,
    parameter int FILL_W      = 4,
    parameter int FINE_W      = 8,
    parameter int DATA_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_fsync,
    input  logic              rx_fsync,
    input  logic              baud_tick,
    input  logic              rx_baud_tick,
    input  logic [FILL_W-1:0] eb_fill,
    input  logic              rd_en,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data
);

    localparam int COARSE_W = $clog2(FRAME_BAUDS + 1);

    logic                running;
    logic [COARSE_W-1:0] coarse_cnt;
    logic [COARSE_W-1:0] coarse_res;
    logic                timeout;
    logic                coarse_done;
    logic [FINE_W-1:0]   fine_res;
    logic                fine_done;
    logic                valid;

    rtd_coarse_timer #(
        .FRAME_BAUDS(FRAME_BAUDS),
        .COARSE_W   (COARSE_W)
    ) u_coarse (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_fsync (tx_fsync),
        .rx_fsync (rx_fsync),
        .baud_tick(baud_tick),
        .running  (running),
        .cnt      (coarse_cnt),
        .result   (coarse_res),
        .timeout  (timeout),
        .done     (coarse_done)
    );

    rtd_phase_counter #(
        .FINE_W(FINE_W)
    ) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_fsync    (tx_fsync),
        .baud_tick   (baud_tick),
        .rx_baud_tick(rx_baud_tick),
        .result      (fine_res),
        .done        (fine_done)
    );

    rtd_regfile #(
        .COARSE_W(COARSE_W),
        .FILL_W  (FILL_W),
        .FINE_W  (FINE_W),
        .DATA_W  (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_fsync   (tx_fsync),
        .coarse_done(coarse_done),
        .fine_done  (fine_done),
        .busy       (running),
        .timeout    (timeout),
        .coarse_res (coarse_res),
        .fine_res   (fine_res),
        .eb_fill    (eb_fill),
        .rd_en      (rd_en),
        .rd_sel     (rd_sel),
        .valid      (valid),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/rtd_measure_sva.sv
// Checker: temporal properties of the round-trip delay unit. It is bound
// into the top level so that it observes the coarse count and the flags.
module rtd_measure_sva #(
    parameter int FRAME_BAUDS = 120,
    parameter int COARSE_W    = 7,
    parameter int DATA_W      = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tx_fsync,
    input logic                rd_en,
    input logic [DATA_W-1:0]   rd_data,
    input logic                running,
    input logic [COARSE_W-1:0] coarse_cnt,
    input logic                timeout,
    input logic                valid
);

    // R3: the coarse count never passes the frame limit.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        coarse_cnt <= COARSE_W'(FRAME_BAUDS));

    // R3: a timeout always leaves the timer stopped.
    a_r3_timeout_stops: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> !running);

    // R2: an idle timer keeps its count.
    a_r2_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !tx_fsync) |=> $stable(coarse_cnt));

    // R9: a frame strobe restarts from zero.
    a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fsync |=> (running && coarse_cnt == '0 && !timeout));

    // R6: a frame strobe withdraws validity.
    a_r6_start_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fsync |=> !valid);

    // R8: read data holds between reads.
    a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

bind rtd_measure_unit rtd_measure_sva #(
    .FRAME_BAUDS(FRAME_BAUDS),
    .COARSE_W   (COARSE_W),
    .DATA_W     (DATA_W)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_fsync  (tx_fsync),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .running   (running),
    .coarse_cnt(coarse_cnt),
    .timeout   (timeout),
    .valid     (valid)
);

// File: tb/rtd_measure_unit_tb_top.sv
// Directed bench for the round-trip delay unit. There is one task per
// scenario, and each task checks its own results.
module rtd_measure_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int FRAME      = 120;
    localparam int DW         = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_fsync = 1'b0;
    logic          rx_fsync = 1'b0;
    logic          baud_tick = 1'b0;
    logic          rx_baud_tick = 1'b0;
    logic [3:0]    eb_fill = '0;
    logic          rd_en = 1'b0;
    logic [1:0]    rd_sel = '0;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rtd_measure_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_fsync    (tx_fsync),
        .rx_fsync    (rx_fsync),
        .baud_tick   (baud_tick),
        .rx_baud_tick(rx_baud_tick),
        .eb_fill     (eb_fill),
        .rd_en       (rd_en),
        .rd_sel      (rd_sel),
        .rd_data     (rd_data)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    // One clock cycle with the given strobes high.
    task automatic step(input logic bt, input logic rbt, input logic txf, input logic rxf);
        @(negedge clk);
        baud_tick = bt; rx_baud_tick = rbt; tx_fsync = txf; rx_fsync = rxf;
        @(posedge clk);
        #1;
        baud_tick = 0; rx_baud_tick = 0; tx_fsync = 0; rx_fsync = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0);
    endtask

    task automatic rd(input logic [1:0] sel, output int val);
        @(negedge clk);
        rd_en = 1; rd_sel = sel;
        @(posedge clk);
        #1;
        rd_en = 0;
        @(negedge clk);
        val = int'(rd_data);
    endtask

    // R1: reset values.
    task automatic t_reset();
        int v;
        rd(0, v); check("R1 status", v, 0);
        rd(1, v); check("R1 coarse", v, 0);
        rd(2, v); check("R1 elastic", v, 0);
        rd(3, v); check("R1 fine", v, 0);
    endtask

    // R2 R4 R5 R6 R7 R8: a plain measurement.
    task automatic t_basic();
        int v;
        step(0, 0, 1, 0);
        step(1, 0, 0, 0);
        idle(6);
        step(0, 1, 0, 0);
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0);
        eb_fill = 4'd9;
        step(0, 0, 0, 1);
        eb_fill = 4'd2;
        rd(0, v); check("R6 R7 status valid", v, 1);
        rd(1, v); check("R2 R8 coarse", v, 5);
        rd(2, v); check("R4 elastic", v, 9);
        rd(3, v); check("R5 fine", v, 7);
        rd(0, v); check("R7 valid cleared on read", v, 0);
    endtask

    // R3 R4: timeout with a late receive strobe ignored.
    task automatic t_timeout();
        int v;
        step(0, 0, 1, 0);
        rd(0, v); check("R7 busy during count", v, 4);
        for (int i = 0; i < FRAME; i++) step(1, 0, 0, 0);
        eb_fill = 4'd3;
        step(0, 0, 0, 1);
        rd(0, v); check("R3 status timeout", v, 2);
        rd(1, v); check("R3 coarse saturated", v, FRAME);
        rd(2, v); check("R4 elastic not recaptured", v, 9);
    endtask

    // R7: the shadow stays unchanged while a second measurement completes.
    task automatic t_shadow();
        int v;
        step(0, 0, 1, 0);
        step(1, 0, 0, 0);
        step(1, 1, 0, 0);
        step(0, 0, 0, 1);
        rd(0, v); check("R6 status after A", v, 1);
        step(0, 0, 1, 0);
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0);
        step(0, 1, 0, 1);
        rd(1, v); check("R7 shadow keeps A", v, 2);
        rd(3, v); check("R7 shadow fine A", v, 1);
        rd(0, v); check("R6 status after B", v, 1);
        rd(1, v); check("R7 snapshot B coarse", v, 4);
    endtask

    // R9: a restart in mid-count.
    task automatic t_restart();
        int v;
        step(0, 0, 1, 0);
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0);
        step(0, 0, 1, 0);
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        step(0, 1, 0, 0);
        step(0, 0, 0, 1);
        rd(0, v); check("R9 status", v, 1);
        rd(1, v); check("R9 coarse restarted", v, 2);
        rd(3, v); check("R9 fine", v, 2);
    endtask

    // R5: an early receive edge is ignored, and saturation.
    task automatic t_fine();
        int v;
        step(0, 0, 1, 0);
        step(0, 1, 0, 0);
        idle(1);
        step(1, 0, 0, 0);
        idle(2);
        step(0, 1, 0, 0);
        step(0, 0, 0, 1);
        rd(0, v); check("R5 status", v, 1);
        rd(3, v); check("R5 early rx edge ignored", v, 3);
        rd(1, v); check("R2 coarse one tick", v, 1);
        step(0, 0, 1, 0);
        step(1, 0, 0, 0);
        idle(300);
        step(0, 1, 0, 0);
        step(0, 0, 0, 1);
        rd(0, v); check("R6 status after saturation run", v, 1);
        rd(3, v); check("R5 fine saturated", v, 255);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_basic();
        t_timeout();
        t_shadow();
        t_restart();
        t_fine();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule